// File: doc/BRIEF.md
# Main Field Identifier

This block tells whether the main picture is in an odd or an even field. It watches the main horizontal and vertical sync inputs on the system clock. For every vertical sync edge it measures how far that edge lies from the nearest horizontal sync edge. A vertical edge close to a horizontal edge, on either side, starts an odd field. A vertical edge near the middle third of the line starts an even field. A vertical edge in any other place is treated as invalid, and the field flag keeps its value.

Two control inputs shape the result. One inverts the reported flag. The other freezes the classified flag. A one-clock strobe marks every change of the classified flag. A status output reports loss of vertical sync. It is raised when a set number of lines pass with no vertical edge, and it is cleared again by the next vertical edge. The windows are parameters in clock cycles. Their defaults suit a clock of about 14.32 MHz: 143 cycles for the near window, and 311 to 598 cycles for the middle window.

Top module: `main_field_id`

## Requirements
- R1: After reset, `field_odd` is 0, `field_chg` is 0 and `vsync_lost` is 1.
- R2: Sync inputs are active high, and only their rising edges count. A vertical rising edge D clocks after a horizontal rising edge, with 0 <= D <= NEAR_CLK, sets the classified flag to odd (1). D = 0 means both edges are seen in the same cycle.
- R3: A vertical rising edge D clocks after a horizontal rising edge, with EVEN_LO <= D <= EVEN_HI, sets the classified flag to even (0).
- R4: A vertical rising edge followed E clocks later by a horizontal rising edge, with 1 <= E <= NEAR_CLK, and not already classified by R2 or R3, sets the flag to odd at that horizontal edge.
- R5: Every other vertical edge leaves the classified flag unchanged. The flag changes only in the cycle after a sync edge.
- R6: `field_odd` equals the classified flag XOR `inv_field`. Changing `inv_field` raises no strobe.
- R7: While `fix_field` is 1, the classified flag holds its value, whatever the vertical edges do.
- R8: `field_chg` is high for exactly one cycle, in the first cycle that shows a changed classified flag. A flag change and the new `field_odd` value appear one clock after the edge that decides them is sampled.
- R9: `vsync_lost` rises on the LOST_LINES-th horizontal rising edge after the last vertical rising edge. It clears in the cycle after a vertical rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hd_in | input | 1 | Main horizontal sync, active high |
| vd_in | input | 1 | Main vertical sync, active high |
| inv_field | input | 1 | Invert the reported field flag |
| fix_field | input | 1 | Freeze the classified field flag |
| field_odd | output | 1 | Reported field: 1 odd, 0 even |
| field_chg | output | 1 | One-cycle pulse when the classified flag changes |
| vsync_lost | output | 1 | 1 while main vertical sync is absent |

## Verification
A horizontal edge and a vertical edge can arrive in the same cycle. At that moment the line-phase counter is being reset and the vertical edge is being classified, all at once. The bench drives both rising edges on the same falling clock edge. It expects an odd field and a strobe. Any wrong decision shows up as a wrong flag or a wrong strobe value in the scoreboard. A second collision is between a pending before-the-line decision and the next horizontal edge. The bench places vertical edges exactly NEAR_CLK and NEAR_CLK+1 clocks before a line start, and checks the flag after that line.

// File: rtl/mfid_pkg.sv
package mfid_pkg;
   typedef enum logic [1:0] {
      VERDICT_NONE = 2'd0,
      VERDICT_ODD  = 2'd1,
      VERDICT_EVEN = 2'd2
   } verdict_t;
endpackage

// File: rtl/mfid_edge.sv
module mfid_edge #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic pulse
);
   localparam logic IDLE_LVL = ~ACTIVE_HIGH;
   logic sig_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_d <= IDLE_LVL;
      else        sig_d <= sig;
   end

   generate
      if (ACTIVE_HIGH) begin : g_rise
         assign pulse = sig & ~sig_d;
      end else begin : g_fall
         assign pulse = ~sig & sig_d;
      end
   endgenerate
endmodule

// File: rtl/mfid_phase.sv
module mfid_phase
   import mfid_pkg::*;
#(
   parameter int NEAR_CLK = 143,
   parameter int EVEN_LO  = 311,
   parameter int EVEN_HI  = 598
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hd_rise,
   input  logic     vd_rise,
   output verdict_t verdict
);
   localparam int CNT_W = $clog2(EVEN_HI + 2);
   localparam int PND_W = $clog2(NEAR_CLK + 1);
   localparam logic [CNT_W-1:0] SAT  = CNT_W'(EVEN_HI + 1);
   localparam logic [CNT_W-1:0] NEAR = CNT_W'(NEAR_CLK);
   localparam logic [CNT_W-1:0] LO   = CNT_W'(EVEN_LO);
   localparam logic [CNT_W-1:0] HI   = CNT_W'(EVEN_HI);
   localparam logic [PND_W-1:0] PND_END = PND_W'(NEAR_CLK);

   logic [CNT_W-1:0] since_hd;
   logic [PND_W-1:0] since_vd;
   logic             waiting;
   verdict_t         immediate;

   always_comb begin
      immediate = VERDICT_NONE;
      if (hd_rise)                                 immediate = VERDICT_ODD;
      else if (since_hd <= NEAR)                   immediate = VERDICT_ODD;
      else if (since_hd >= LO && since_hd <= HI)   immediate = VERDICT_EVEN;
   end

   always_comb begin
      if (vd_rise)                 verdict = immediate;
      else if (waiting && hd_rise) verdict = VERDICT_ODD;
      else                         verdict = VERDICT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_hd <= SAT;
         since_vd <= '0;
         waiting  <= 1'b0;
      end else begin
         if (hd_rise)              since_hd <= CNT_W'(1);
         else if (since_hd != SAT) since_hd <= since_hd + 1'b1;

         if (vd_rise) begin
            waiting  <= (immediate == VERDICT_NONE);
            since_vd <= PND_W'(1);
         end else if (waiting) begin
            if (hd_rise || since_vd == PND_END) waiting <= 1'b0;
            else                                since_vd <= since_vd + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mfid_field.sv
module mfid_field
   import mfid_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  verdict_t verdict,
   input  logic     hold,
   output logic     raw_odd,
   output logic     change
);
   logic next_odd;

   always_comb begin
      next_odd = raw_odd;
      if (!hold) begin
         if (verdict == VERDICT_ODD)       next_odd = 1'b1;
         else if (verdict == VERDICT_EVEN) next_odd = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_odd <= 1'b0;
         change  <= 1'b0;
      end else begin
         raw_odd <= next_odd;
         change  <= (next_odd != raw_odd);
      end
   end
endmodule

// File: rtl/mfid_loss.sv
module mfid_loss #(
   parameter int LOST_LINES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hd_rise,
   input  logic vd_rise,
   output logic lost
);
   localparam int LN_W = $clog2(LOST_LINES + 1);
   localparam logic [LN_W-1:0] LAST = LN_W'(LOST_LINES - 1);
   logic [LN_W-1:0] lines;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines <= '0;
         lost  <= 1'b1;
      end else if (vd_rise) begin
         lines <= '0;
         lost  <= 1'b0;
      end else if (hd_rise && !lost) begin
         if (lines == LAST) begin
            lines <= '0;
            lost  <= 1'b1;
         end else begin
            lines <= lines + 1'b1;
         end
      end
   end
endmodule

// File: rtl/main_field_id.sv
module main_field_id
   import mfid_pkg::*;
#(
   parameter int NEAR_CLK       = 143,
   parameter int EVEN_LO        = 311,
   parameter int EVEN_HI        = 598,
   parameter int LOST_LINES     = 400,
   parameter bit HD_ACTIVE_HIGH = 1'b1,
   parameter bit VD_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hd_in,
   input  logic vd_in,
   input  logic inv_field,
   input  logic fix_field,
   output logic field_odd,
   output logic field_chg,
   output logic vsync_lost
);
   generate
      if (NEAR_CLK < 1 || NEAR_CLK >= EVEN_LO || EVEN_LO > EVEN_HI) begin : g_bad_window
         $error("main_field_id: windows must satisfy 1 <= NEAR_CLK < EVEN_LO <= EVEN_HI");
      end
      if (LOST_LINES < 2) begin : g_bad_lost
         $error("main_field_id: LOST_LINES must be at least 2");
      end
   endgenerate

   logic     hd_rise;
   logic     vd_rise;
   logic     raw_odd;
   verdict_t verdict;

   mfid_edge #(.ACTIVE_HIGH(HD_ACTIVE_HIGH)) i_hd_edge (
      .clk(clk), .rst_n(rst_n), .sig(hd_in), .pulse(hd_rise));

   mfid_edge #(.ACTIVE_HIGH(VD_ACTIVE_HIGH)) i_vd_edge (
      .clk(clk), .rst_n(rst_n), .sig(vd_in), .pulse(vd_rise));

   mfid_phase #(.NEAR_CLK(NEAR_CLK), .EVEN_LO(EVEN_LO), .EVEN_HI(EVEN_HI)) i_phase (
      .clk(clk), .rst_n(rst_n), .hd_rise(hd_rise), .vd_rise(vd_rise), .verdict(verdict));

   mfid_field i_field (
      .clk(clk), .rst_n(rst_n), .verdict(verdict), .hold(fix_field),
      .raw_odd(raw_odd), .change(field_chg));

   mfid_loss #(.LOST_LINES(LOST_LINES)) i_loss (
      .clk(clk), .rst_n(rst_n), .hd_rise(hd_rise), .vd_rise(vd_rise), .lost(vsync_lost));

   assign field_odd = raw_odd ^ inv_field;
endmodule

// File: rtl/main_field_id_chk.sv
module main_field_id_chk (
   input logic clk,
   input logic rst_n,
   input logic hd_rise,
   input logic vd_rise,
   input logic raw_odd,
   input logic fix_field,
   input logic field_chg,
   input logic vsync_lost
);
   assert_strobe_marks_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      field_chg |-> (raw_odd != $past(raw_odd)));

   assert_change_is_strobed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_odd != $past(raw_odd)) |-> field_chg);

   assert_change_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_odd != $past(raw_odd)) |-> $past(hd_rise || vd_rise));

   assert_fix_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fix_field) |-> $stable(raw_odd));

   assert_vd_clears_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vd_rise |=> !vsync_lost);

   assert_lost_on_hd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync_lost) |-> $past(hd_rise));
endmodule

bind main_field_id main_field_id_chk i_chk (
   .clk(clk), .rst_n(rst_n), .hd_rise(hd_rise), .vd_rise(vd_rise),
   .raw_odd(raw_odd), .fix_field(fix_field), .field_chg(field_chg),
   .vsync_lost(vsync_lost));

// File: tb/test_main_field_id.sv
`timescale 1ns/1ps
module test_main_field_id;
   localparam int LINE  = 910;
   localparam int NEAR  = 143;
   localparam int LO    = 311;
   localparam int HI    = 598;
   localparam int LOSTN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hd_in = 1'b0, vd_in = 1'b0, inv_field = 1'b0, fix_field = 1'b0;
   logic field_odd, field_chg, vsync_lost;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic exp_q[$];

   always #5 clk = ~clk;

   main_field_id #(.NEAR_CLK(NEAR), .EVEN_LO(LO), .EVEN_HI(HI), .LOST_LINES(LOSTN)) i_main_field_id (
      .clk(clk), .rst_n(rst_n), .hd_in(hd_in), .vd_in(vd_in),
      .inv_field(inv_field), .fix_field(fix_field),
      .field_odd(field_odd), .field_chg(field_chg), .vsync_lost(vsync_lost));

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // scoreboard monitor: each strobe must match the next queued field value (R8)
   initial begin
      forever begin
         @(posedge clk); #2;
         if (rst_n && field_chg) begin
            if (exp_q.size() == 0) begin
               total++; bad++;
               $display("FAIL R8: actual=strobe expected=no strobe at %0t", $time);
            end else begin
               logic e;
               e = exp_q.pop_front();
               chk("R8 strobe field value", field_odd, e);
            end
         end
      end
   end

   // one line: HD high for 60 clocks; VD rises vd_at clocks after HD (-1: none)
   task automatic run_line(input int vd_at);
      for (int i = 0; i < LINE; i++) begin
         @(negedge clk);
         hd_in = (i < 60);
         vd_in = (vd_at >= 0) && (i >= vd_at) && (i < vd_at + 50);
      end
   endtask

   task automatic settle();
      @(posedge clk); #2;
   endtask

   initial begin
      #(10 * 200000);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk("R1 field", field_odd, 1'b0);
      chk("R1 strobe", field_chg, 1'b0);
      chk("R1 lost", vsync_lost, 1'b1);

      exp_q.push_back(1'b1); run_line(50);  settle(); chk("R2 D=50", field_odd, 1'b1);
      chk("R9 lost cleared by VD", vsync_lost, 1'b0);
      exp_q.push_back(1'b0); run_line(400); settle(); chk("R3 D=400", field_odd, 1'b0);
      exp_q.push_back(1'b1); run_line(NEAR); settle(); chk("R2 D=NEAR", field_odd, 1'b1);
      exp_q.push_back(1'b0); run_line(LO);  settle(); chk("R3 D=EVEN_LO", field_odd, 1'b0);
      exp_q.push_back(1'b1); run_line(0);   settle(); chk("R2 same cycle", field_odd, 1'b1);
      exp_q.push_back(1'b0); run_line(HI);  settle(); chk("R3 D=EVEN_HI", field_odd, 1'b0);

      // invalid phases leave the flag alone (R5)
      exp_q.push_back(1'b1); run_line(50); settle();
      run_line(200);    settle(); chk("R5 D=200", field_odd, 1'b1);
      run_line(NEAR+1); settle(); chk("R5 D=NEAR+1", field_odd, 1'b1);
      run_line(LO-1);   settle(); chk("R5 D=EVEN_LO-1", field_odd, 1'b1);
      run_line(HI+1);   run_line(-1); settle(); chk("R5 D=EVEN_HI+1", field_odd, 1'b1);

      // VD shortly before HD (R4)
      exp_q.push_back(1'b0); run_line(400); settle();
      exp_q.push_back(1'b1); run_line(LINE-100); run_line(-1); settle();
      chk("R4 E=100", field_odd, 1'b1);
      exp_q.push_back(1'b0); run_line(400); settle();
      exp_q.push_back(1'b1); run_line(LINE-NEAR); run_line(-1); settle();
      chk("R4 E=NEAR", field_odd, 1'b1);
      exp_q.push_back(1'b0); run_line(400); settle();
      run_line(LINE-NEAR-1); run_line(-1); settle();
      chk("R5 E=NEAR+1", field_odd, 1'b0);

      // inversion (R6)
      @(negedge clk); inv_field = 1'b1;
      settle(); chk("R6 inverted even", field_odd, 1'b1);
      chk("R6 no strobe on invert", field_chg, 1'b0);
      exp_q.push_back(1'b0); run_line(50); settle();
      chk("R6 inverted odd", field_odd, 1'b0);
      @(negedge clk); inv_field = 1'b0;
      settle(); chk("R6 plain odd", field_odd, 1'b1);

      // freeze (R7)
      @(negedge clk); fix_field = 1'b1;
      run_line(400); settle(); chk("R7 frozen", field_odd, 1'b1);
      @(negedge clk); fix_field = 1'b0;
      exp_q.push_back(1'b0); run_line(400); settle(); chk("R7 released", field_odd, 1'b0);

      // loss of vertical sync (R9)
      for (int n = 0; n < LOSTN - 1; n++) run_line(-1);
      settle(); chk("R9 not yet lost", vsync_lost, 1'b0);
      run_line(-1); settle(); chk("R9 lost", vsync_lost, 1'b1);
      exp_q.push_back(1'b1); run_line(50); settle();
      chk("R9 regained", vsync_lost, 1'b0);
      chk("R2 after loss", field_odd, 1'b1);

      repeat (4) settle();
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R8: actual=%0d strobes missing expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule